// File: doc/BRIEF.md
# Narrow-to-wide bus lane adapter

This block attaches a target with a 64-bit data path to a segment of a simple request/acknowledge local bus whose data path is only 16 bits wide. It performs no transfer splitting. Each segment transfer becomes exactly one target transfer, and that transfer touches one 16-bit lane of the target.

The lane is chosen by the two address bits just above the segment's byte offset. The address itself reaches the target unshifted, so the target's resources appear in the same order as they would on a segment of equal width. The two segment byte enables (active low) are steered onto the selected lane. Every other target byte enable is held inactive, so the target sees an ordinary partial-width access.

The 16-bit write data is copied onto all four lanes. The read data of the selected lane is returned to the segment. Request and command flow to the target unchanged, and the acknowledge flows back unchanged. The whole path is combinational and settles within one clock period.

Top module: `bus_lane_adapter`

## Requirements
- R1: Target byte enables are active low (0 lets a byte through, 1 blocks it). Target enables 2L and 2L+1 equal segment enables 0 and 1 of the selected lane L. All other target enables are 1.
- R2: The selected lane L is the value of address bits [2:1]. Address bit 0 and bits above 2 have no effect on the lane choice.
- R3: The target write data carries the segment write data on each of its four 16-bit lanes, in bits [16L+15:16L] for L = 0..3.
- R4: The segment read data equals target read bits [15:0], [31:16], [47:32] or [63:48] for lane 0, 1, 2 or 3.
- R5: The target address equals the segment address bit for bit, without shifting.
- R6: The target request and command equal the segment request and command. The segment acknowledge equals the target acknowledge.
- R7: All outputs follow their inputs within the same clock period. A one-cycle write followed by a read of the same lane returns the written halfword.
- R8: A transfer with both segment byte enables at 1 leaves every target byte enable at 1, so a write changes no target byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_req | input | 1 | Segment transfer request |
| s_addr | input | ADDR_W (26) | Segment byte address |
| s_nbe | input | SEG_W/8 (2) | Segment byte enables, active low |
| s_cmd | input | CMD_W (3) | Segment command code |
| s_wdata | input | SEG_W (16) | Segment write data |
| s_ack | output | 1 | Acknowledge returned to the segment |
| s_rdata | output | SEG_W (16) | Read data returned to the segment |
| t_req | output | 1 | Request to the target |
| t_addr | output | ADDR_W (26) | Address to the target, unshifted |
| t_nbe | output | TGT_W/8 (8) | Target byte enables, active low |
| t_cmd | output | CMD_W (3) | Command to the target |
| t_wdata | output | TGT_W (64) | Write data to the target, lane-replicated |
| t_ack | input | 1 | Target acknowledge |
| t_rdata | input | TGT_W (64) | Target read data |

## Verification
The bench builds the adapter with its default 16-bit segment and 64-bit target. With these widths there are only four lanes and four byte-enable patterns, so every lane-by-enable combination is driven. A behavioural 64-bit register target records writes. After each write, all four lanes are read back and compared with a halfword image kept in the bench. This shows that a write lands in one lane only, and that the read mux returns the matching slice for every select value.

// File: rtl/bus_lane_adapter.sv
module bus_lane_adapter #(
  parameter int SEG_W  = 16,
  parameter int TGT_W  = 64,
  parameter int ADDR_W = 26,
  parameter int CMD_W  = 3
) (
  input  logic                 s_req,
  input  logic [ADDR_W-1:0]    s_addr,
  input  logic [SEG_W/8-1:0]   s_nbe,
  input  logic [CMD_W-1:0]     s_cmd,
  input  logic [SEG_W-1:0]     s_wdata,
  output logic                 s_ack,
  output logic [SEG_W-1:0]     s_rdata,
  output logic                 t_req,
  output logic [ADDR_W-1:0]    t_addr,
  output logic [TGT_W/8-1:0]   t_nbe,
  output logic [CMD_W-1:0]     t_cmd,
  output logic [TGT_W-1:0]     t_wdata,
  input  logic                 t_ack,
  input  logic [TGT_W-1:0]     t_rdata
);
  localparam int SEG_B   = SEG_W / 8;
  localparam int LANES   = TGT_W / SEG_W;
  localparam int SEL_W   = $clog2(LANES);
  localparam int SEL_LSB = $clog2(SEG_B);

  logic [SEL_W-1:0] lane;
  assign lane = s_addr[SEL_LSB +: SEL_W];

  assign t_req  = s_req;
  assign t_cmd  = s_cmd;
  assign t_addr = s_addr;
  assign s_ack  = t_ack;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign t_nbe[g*SEG_B +: SEG_B]   = (lane == SEL_W'(g)) ? s_nbe : '1;
    assign t_wdata[g*SEG_W +: SEG_W] = s_wdata;
  end

  always_comb s_rdata = t_rdata[lane*SEG_W +: SEG_W];

  always_comb begin
    assert_enable_count_R1: assert ($countones(~t_nbe) == $countones(~s_nbe))
      else $error("R1: target enables active %0d, segment %0d", $countones(~t_nbe), $countones(~s_nbe));
    assert_blocked_stays_blocked_R8: assert (!(&s_nbe) || (&t_nbe))
      else $error("R8: blocked transfer enabled a target byte");
    assert_top_lane_copy_R3: assert (t_wdata[TGT_W-1 -: SEG_W] == s_wdata)
      else $error("R3: top lane write data differs");
    assert_ack_return_R6: assert (s_ack == t_ack)
      else $error("R6: acknowledge not returned");
    assert_addr_pass_R5: assert (t_addr == s_addr)
      else $error("R5: address altered");
  end
endmodule

// File: tb/sim_bus_lane_adapter.sv
module sim_bus_lane_adapter;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        s_req, s_ack, t_req, t_ack;
  logic [25:0] s_addr, t_addr;
  logic [1:0]  s_nbe;
  logic [7:0]  t_nbe;
  logic [2:0]  s_cmd, t_cmd;
  logic [15:0] s_wdata, s_rdata;
  logic [63:0] t_wdata, t_rdata;

  bus_lane_adapter u0 (.*);

  localparam logic [63:0] INIT = 64'h0123_4567_89AB_CDEF;
  logic [63:0] mem;
  always_ff @(posedge clk)
    if (!rst_n) mem <= INIT;
    else if (t_req && t_cmd[0])
      for (int b = 0; b < 8; b++)
        if (!t_nbe[b]) mem[8*b +: 8] <= t_wdata[8*b +: 8];
  assign t_ack   = t_req;
  assign t_rdata = mem;

  int total = 0, bad = 0;
  logic [63:0] img;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_all(input string tag);
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      s_req = 1; s_cmd = 3'b010; s_nbe = 2'b00;
      s_addr = 26'h2A0_0000 | 26'(l << 1);
      #1;
      chk({tag, " R4 R7 read lane"}, 64'(s_rdata), 64'(img[16*l +: 16]));
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    s_req = 0; s_addr = 0; s_nbe = 2'b11; s_cmd = 0; s_wdata = 0;
    img = INIT;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R6 idle request", 64'(t_req), 0);
    chk("R6 idle ack", 64'(s_ack), 0);
    chk("R8 idle enables", 64'(t_nbe), 64'hFF);
    chk("R4 reset lane0", 64'(s_rdata), 64'(INIT[15:0]));

    for (int l = 0; l < 4; l++) begin
      for (int n = 0; n < 4; n++) begin
        logic [7:0]  en;
        logic [15:0] w;
        logic [25:0] a;
        w = 16'(16'h1357 * (l * 4 + n + 1) + 16'h0F0F);
        a = 26'(((l * 4 + n) * 37) << 3) | 26'(l << 1) | 26'(n & 1);
        en = 8'hFF;
        en[2*l +: 2] = 2'(n);
        @(negedge clk);
        s_req = 1; s_cmd = 3'b101; s_nbe = 2'(n); s_wdata = w; s_addr = a;
        #1;
        chk("R1 R2 lane enables", 64'(t_nbe), 64'(en));
        chk("R3 replicated write", t_wdata, {4{w}});
        chk("R5 address pass", 64'(t_addr), 64'(a));
        chk("R6 command pass", 64'(t_cmd), 64'(3'b101));
        chk("R6 ack return", 64'(s_ack), 1);
        if (n == 3) chk("R8 blocked", 64'(t_nbe), 64'hFF);
        @(posedge clk);
        for (int b = 0; b < 2; b++)
          if (!n[b]) img[16*l + 8*b +: 8] = w[8*b +: 8];
        read_all($sformatf("lane%0d nbe%0d", l, n));
      end
    end

    @(negedge clk);
    s_req = 0; s_cmd = 3'b001; s_nbe = 2'b00;
    #1;
    chk("R6 request dropped", 64'(t_req), 0);
    @(posedge clk);
    read_all("no-request write");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule